// File: doc/BRIEF.md
# SDRAM Command Legality Checker

This block passively watches the command pins of a two-bank (by default) SDRAM bus. Every clock edge it turns the chip-select, row-strobe, column-strobe and write-enable levels into a command. It holds a small state record and an elapsed-cycle counter for each bank. Each command is then judged against the state of the bank it targets, or of all banks when the command affects the whole device. The block never drives the bus.

A command can fail in two ways. If the target bank's state does not permit it, the block pulses `illegal_o`. If the command is allowed but arrives before a minimum spacing has passed, the block pulses `timing_o`. A bank that stays open past the longest allowed open time also pulses `timing_o`.

With both pulses, `rule_o` gives a code for the rule that failed. All three outputs are registered, so they appear in the cycle after the offending command. The timing limits are elaboration parameters.

Top module: `sdram_cmd_checker`

## Requirements
- R1: When chip-select is high the command is a deselect. When chip-select is low, `{ras_n,cas_n,we_n}` decodes as follows: 000 mode set, 001 refresh, 010 precharge, 011 activate, 100 write, 101 read, 110 burst stop, 111 no-op. The outputs are registered and report on the command of the previous cycle. `rule_o` takes these values: 0 none, 1 bank busy, 2 banks not all idle, 3 activate to open bank, 4 access to closed bank, 5 row-to-column too early, 6 precharge too early, 7 activate-to-activate too early, 8 row open too long. A synchronous reset clears all outputs, returns every bank to idle and leaves every spacing counter expired.
- R2: A refresh holds every bank busy for T_RC cycles. A command issued d cycles after the refresh, with d < T_RC, is flagged illegal with code 1 unless it is a no-op or a deselect. From d = T_RC onward the bank is idle again.
- R3: A mode set holds every bank busy for T_MRD (2) cycles. During that time every command other than no-op or deselect is flagged illegal with code 1.
- R4: A mode set or a refresh issued while any bank is open is flagged illegal with code 2. When all banks are idle, the same command is legal.
- R5: A read or write issued d cycles after its bank's activate, with d < T_RCD, raises `timing_o` with code 5.
- R6: A precharge to an open bank issued d cycles after its activate, with d < T_RAS_MIN, raises `timing_o` with code 6.
- R7: An activate issued d cycles after an activate to a different bank, with d < T_RRD, raises `timing_o` with code 7.
- R8: A bank-addressed command is judged by the addressed bank's own state. An activate to an open bank gives code 3. A read or write to an idle bank gives code 4. The same command aimed at the other bank is judged on that bank's state alone.
- R9: A read or write with `a10` high closes its bank. A read or write to that bank in the following cycle is flagged with code 4, and a new activate to it is legal. With `a10` low the bank stays open.
- R10: A bank that is still open T_RAS_MAX cycles after its activate, with no precharge issued in that cycle, raises a single `timing_o` pulse with code 8. A precharge issued exactly T_RAS_MAX cycles after the activate raises no flag.
- R11: A refresh with `cke` low enters self-refresh. The banks stay busy for as long as `cke` remains low. If `cke` first returns high in cycle X, the banks become idle in cycle X + T_RC.
- R12: A no-op with `cke` low (power-down) raises no flag and leaves the bank states and counters unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock-enable pin level |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BANK_W | Bank address |
| a10 | input | 1 | Auto-close flag sampled with read and write |
| illegal_o | output | 1 | Pulse: previous command was not allowed in its bank state |
| timing_o | output | 1 | Pulse: a minimum spacing or the maximum open time was broken |
| rule_o | output | 4 | Code of the rule that failed, 0 when none |

## Verification
Each spacing rule gets a sweep. The gap between the opening command and the tested command is stepped one cycle at a time through the limit, so that an off-by-one in any counter shows up as a flag in the wrong sweep step. Separate sequences target a bank that is idle and one that is open. Comparing them separates judging a command by the addressed bank's state from judging it by any bank's state. Self-refresh runs are issued at the last illegal cycle and at the first legal cycle after `cke` returns. Power-down runs test that a no-op with `cke` low leaves the later tRCD behaviour unchanged.

// File: rtl/sdram_chk_pkg.sv
package sdram_chk_pkg;

   typedef enum logic [3:0] {
      CMD_MRS, CMD_REF, CMD_PRE, CMD_ACT,
      CMD_WR,  CMD_RD,  CMD_BST, CMD_NOP, CMD_DSEL
   } cmd_e;

   typedef enum logic [1:0] {
      BK_IDLE, BK_OPEN, BK_REF, BK_MODE
   } bank_e;

   typedef enum logic [3:0] {
      RULE_NONE    = 4'd0,
      RULE_BUSY    = 4'd1,
      RULE_NOTIDLE = 4'd2,
      RULE_REOPEN  = 4'd3,
      RULE_CLOSED  = 4'd4,
      RULE_RCD     = 4'd5,
      RULE_RASMIN  = 4'd6,
      RULE_RRD     = 4'd7,
      RULE_RASMAX  = 4'd8
   } rule_e;

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
   import sdram_chk_pkg::*;
(
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   output cmd_e cmd
);
   always_comb begin
      if (cs_n) begin
         cmd = CMD_DSEL;
      end else begin
         case ({ras_n, cas_n, we_n})
            3'b000:  cmd = CMD_MRS;
            3'b001:  cmd = CMD_REF;
            3'b010:  cmd = CMD_PRE;
            3'b011:  cmd = CMD_ACT;
            3'b100:  cmd = CMD_WR;
            3'b101:  cmd = CMD_RD;
            3'b110:  cmd = CMD_BST;
            default: cmd = CMD_NOP;
         endcase
      end
   end
endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
   import sdram_chk_pkg::*;
#(
   parameter int AGE_W   = 5,
   parameter int AGE_MAX = 21,
   parameter int T_RC    = 6,
   parameter int T_MRD   = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             accept,
   input  cmd_e             cmd,
   input  logic             hit,
   input  logic             a10,
   input  logic             hold_ref,
   output bank_e            state,
   output logic [AGE_W-1:0] age
);
   localparam logic [AGE_W-1:0] AGE_TOP  = AGE_W'(AGE_MAX);
   localparam logic [AGE_W-1:0] REF_LAST = AGE_W'(T_RC - 1);
   localparam logic [AGE_W-1:0] MRD_LAST = AGE_W'(T_MRD - 1);
   localparam logic [AGE_W-1:0] ONE      = AGE_W'(1);

   logic closes;
   assign closes = hit && ((cmd == CMD_PRE) ||
                           (((cmd == CMD_RD) || (cmd == CMD_WR)) && a10));

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= BK_IDLE;
         age   <= AGE_TOP;
      end else if (accept && (cmd == CMD_MRS)) begin
         state <= BK_MODE;
         age   <= ONE;
      end else if (accept && (cmd == CMD_REF)) begin
         state <= BK_REF;
         age   <= ONE;
      end else if (accept && hit && (cmd == CMD_ACT)) begin
         state <= BK_OPEN;
         age   <= ONE;
      end else if (accept && closes) begin
         state <= BK_IDLE;
         age   <= ONE;
      end else begin
         case (state)
            BK_REF: begin
               if (hold_ref) begin
                  age <= ONE;
               end else if (age >= REF_LAST) begin
                  state <= BK_IDLE;
                  age   <= ONE;
               end else begin
                  age <= age + ONE;
               end
            end
            BK_MODE: begin
               if (age >= MRD_LAST) begin
                  state <= BK_IDLE;
                  age   <= ONE;
               end else begin
                  age <= age + ONE;
               end
            end
            default: begin
               if (age != AGE_TOP) age <= age + ONE;
            end
         endcase
      end
   end
endmodule

// File: rtl/sdram_rule_eval.sv
module sdram_rule_eval
   import sdram_chk_pkg::*;
#(
   parameter int BANK_W    = 1,
   parameter int NUM_BANKS = 2,
   parameter int AGE_W     = 5,
   parameter int T_RCD     = 2,
   parameter int T_RAS_MIN = 4,
   parameter int T_RAS_MAX = 20,
   parameter int T_RRD     = 2
) (
   input  cmd_e              cmd,
   input  logic [BANK_W-1:0] ba,
   input  logic              a10,
   input  bank_e             bank_st  [NUM_BANKS],
   input  logic [AGE_W-1:0]  bank_age [NUM_BANKS],
   input  logic [AGE_W-1:0]  rrd_age,
   input  logic [BANK_W-1:0] rrd_bank,
   output logic              accept,
   output logic              ill,
   output logic              tim,
   output rule_e             rule
);
   localparam logic [AGE_W-1:0] LIM_RCD = AGE_W'(T_RCD);
   localparam logic [AGE_W-1:0] LIM_RAS = AGE_W'(T_RAS_MIN);
   localparam logic [AGE_W-1:0] LIM_MAX = AGE_W'(T_RAS_MAX);
   localparam logic [AGE_W-1:0] LIM_RRD = AGE_W'(T_RRD);

   bank_e            sel_st;
   logic [AGE_W-1:0] sel_age;
   logic             any_busy, any_open, is_rw, bank_cmd, all_cmd;
   logic             cmd_tim, ras_max;
   rule_e            ill_code, tim_code;

   always_comb begin
      sel_st   = bank_st[ba];
      sel_age  = bank_age[ba];
      is_rw    = (cmd == CMD_RD) || (cmd == CMD_WR);
      bank_cmd = is_rw || (cmd == CMD_PRE) || (cmd == CMD_ACT) || (cmd == CMD_BST);
      all_cmd  = (cmd == CMD_MRS) || (cmd == CMD_REF);
      any_busy = 1'b0;
      any_open = 1'b0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if ((bank_st[b] == BK_REF) || (bank_st[b] == BK_MODE)) any_busy = 1'b1;
         if (bank_st[b] == BK_OPEN) any_open = 1'b1;
      end

      ill      = 1'b1;
      ill_code = RULE_NONE;
      if (bank_cmd && ((sel_st == BK_REF) || (sel_st == BK_MODE)))
         ill_code = RULE_BUSY;
      else if (all_cmd && any_busy)
         ill_code = RULE_BUSY;
      else if (all_cmd && any_open)
         ill_code = RULE_NOTIDLE;
      else if ((cmd == CMD_ACT) && (sel_st == BK_OPEN))
         ill_code = RULE_REOPEN;
      else if (is_rw && (sel_st == BK_IDLE))
         ill_code = RULE_CLOSED;
      else
         ill = 1'b0;
      accept = !ill;

      cmd_tim  = accept;
      tim_code = RULE_NONE;
      if (is_rw && (sel_age < LIM_RCD))
         tim_code = RULE_RCD;
      else if ((cmd == CMD_PRE) && (sel_st == BK_OPEN) && (sel_age < LIM_RAS))
         tim_code = RULE_RASMIN;
      else if ((cmd == CMD_ACT) && (rrd_bank != ba) && (rrd_age < LIM_RRD))
         tim_code = RULE_RRD;
      else
         cmd_tim = 1'b0;

      ras_max = 1'b0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if ((bank_st[b] == BK_OPEN) && (bank_age[b] == LIM_MAX) &&
             !(accept && (ba == BANK_W'(b)) &&
               ((cmd == CMD_PRE) || (is_rw && a10))))
            ras_max = 1'b1;
      end

      tim = cmd_tim || ras_max;
      if (ill)          rule = ill_code;
      else if (cmd_tim) rule = tim_code;
      else if (ras_max) rule = RULE_RASMAX;
      else              rule = RULE_NONE;
   end
endmodule

// File: rtl/sdram_cmd_checker.sv
module sdram_cmd_checker
   import sdram_chk_pkg::*;
#(
   parameter int BANK_W    = 1,
   parameter int T_RC      = 6,
   parameter int T_MRD     = 2,
   parameter int T_RCD     = 2,
   parameter int T_RAS_MIN = 4,
   parameter int T_RAS_MAX = 20,
   parameter int T_RRD     = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cke,
   input  logic              cs_n,
   input  logic              ras_n,
   input  logic              cas_n,
   input  logic              we_n,
   input  logic [BANK_W-1:0] ba,
   input  logic              a10,
   output logic              illegal_o,
   output logic              timing_o,
   output logic [3:0]        rule_o
);
   localparam int NUM_BANKS = 1 << BANK_W;
   localparam int MAX_A     = (T_RAS_MAX + 1 > T_RC) ? T_RAS_MAX + 1 : T_RC;
   localparam int MAX_B     = (T_RRD > T_RCD) ? T_RRD : T_RCD;
   localparam int AGE_MAX   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int AGE_W     = $clog2(AGE_MAX + 1);
   localparam logic [AGE_W-1:0] AGE_TOP = AGE_W'(AGE_MAX);

   if (BANK_W < 1)              begin : g_bad_bank $error("BANK_W must be at least 1"); end
   if (T_RC < 2)                begin : g_bad_rc   $error("T_RC must be at least 2"); end
   if (T_MRD < 1)               begin : g_bad_mrd  $error("T_MRD must be at least 1"); end
   if (T_RCD < 1)               begin : g_bad_rcd  $error("T_RCD must be at least 1"); end
   if (T_RAS_MAX < T_RAS_MIN)   begin : g_bad_ras  $error("T_RAS_MAX below T_RAS_MIN"); end

   cmd_e              cmd;
   bank_e             bank_st  [NUM_BANKS];
   logic [AGE_W-1:0]  bank_age [NUM_BANKS];
   logic [AGE_W-1:0]  rrd_age;
   logic [BANK_W-1:0] rrd_bank;
   logic              self_ref, accept, ill_n, tim_n;
   rule_e             rule_n;

   sdram_cmd_decode u_dec (
      .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
   );

   for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
      sdram_bank_track #(
         .AGE_W(AGE_W), .AGE_MAX(AGE_MAX), .T_RC(T_RC), .T_MRD(T_MRD)
      ) u_trk (
         .clk(clk), .rst(rst), .accept(accept), .cmd(cmd),
         .hit(ba == BANK_W'(g)), .a10(a10), .hold_ref(self_ref),
         .state(bank_st[g]), .age(bank_age[g])
      );
   end

   sdram_rule_eval #(
      .BANK_W(BANK_W), .NUM_BANKS(NUM_BANKS), .AGE_W(AGE_W),
      .T_RCD(T_RCD), .T_RAS_MIN(T_RAS_MIN), .T_RAS_MAX(T_RAS_MAX), .T_RRD(T_RRD)
   ) u_eval (
      .cmd(cmd), .ba(ba), .a10(a10), .bank_st(bank_st), .bank_age(bank_age),
      .rrd_age(rrd_age), .rrd_bank(rrd_bank),
      .accept(accept), .ill(ill_n), .tim(tim_n), .rule(rule_n)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         self_ref  <= 1'b0;
         rrd_age   <= AGE_TOP;
         rrd_bank  <= '0;
         illegal_o <= 1'b0;
         timing_o  <= 1'b0;
         rule_o    <= 4'd0;
      end else begin
         if (accept && (cmd == CMD_REF) && !cke) self_ref <= 1'b1;
         else if (self_ref && cke)               self_ref <= 1'b0;
         if (accept && (cmd == CMD_ACT)) begin
            rrd_age  <= AGE_W'(1);
            rrd_bank <= ba;
         end else if (rrd_age != AGE_TOP) begin
            rrd_age <= rrd_age + AGE_W'(1);
         end
         illegal_o <= ill_n;
         timing_o  <= tim_n;
         rule_o    <= 4'(rule_n);
      end
   end
endmodule

// File: rtl/sdram_cmd_checker_sva.sv
module sdram_cmd_checker_sva
   import sdram_chk_pkg::*;
#(
   parameter int BANK_W    = 1,
   parameter int NUM_BANKS = 2,
   parameter int AGE_W     = 5,
   parameter int T_RCD     = 2,
   parameter int T_RAS_MIN = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              cs_n,
   input logic              ras_n,
   input logic              cas_n,
   input logic              we_n,
   input logic [BANK_W-1:0] ba,
   input bank_e             bank_st  [NUM_BANKS],
   input logic [AGE_W-1:0]  bank_age [NUM_BANKS],
   input logic              illegal_o,
   input logic              timing_o,
   input logic [3:0]        rule_o
);
   localparam logic [AGE_W-1:0] LIM_RCD = AGE_W'(T_RCD);
   localparam logic [AGE_W-1:0] LIM_RAS = AGE_W'(T_RAS_MIN);

   logic active_cmd, rw_cmd, pre_cmd, tgt_busy, tgt_open;
   assign active_cmd = !cs_n && !(ras_n && cas_n && we_n);
   assign rw_cmd     = !cs_n && ras_n && !cas_n;
   assign pre_cmd    = !cs_n && !ras_n && cas_n && !we_n;
   assign tgt_busy   = (bank_st[ba] == BK_REF) || (bank_st[ba] == BK_MODE);
   assign tgt_open   = (bank_st[ba] == BK_OPEN);

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (!illegal_o && !timing_o && (rule_o == 4'd0)));

   // R1
   code_class_chk: assert property (@(posedge clk) disable iff (rst)
      (illegal_o |-> ((rule_o >= 4'd1) && (rule_o <= 4'd4))) and
      ((!illegal_o && !timing_o) |-> (rule_o == 4'd0)));

   // R2
   busy_cmd_chk: assert property (@(posedge clk) disable iff (rst)
      (active_cmd && tgt_busy) |=> (illegal_o && (rule_o == 4'd1)));

   // R5
   rcd_early_chk: assert property (@(posedge clk) disable iff (rst)
      (rw_cmd && tgt_open && (bank_age[ba] < LIM_RCD)) |=> (timing_o && (rule_o == 4'd5)));

   // R6
   ras_early_chk: assert property (@(posedge clk) disable iff (rst)
      (pre_cmd && tgt_open && (bank_age[ba] < LIM_RAS)) |=> (timing_o && (rule_o == 4'd6)));
endmodule

bind sdram_cmd_checker sdram_cmd_checker_sva #(
   .BANK_W(BANK_W), .NUM_BANKS(NUM_BANKS), .AGE_W(AGE_W),
   .T_RCD(T_RCD), .T_RAS_MIN(T_RAS_MIN)
) u_sva (
   .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
   .ba(ba), .bank_st(bank_st), .bank_age(bank_age),
   .illegal_o(illegal_o), .timing_o(timing_o), .rule_o(rule_o)
);

// File: tb/sdram_cmd_checker_tb.sv
`timescale 1ns/1ps
module sdram_cmd_checker_tb;
   localparam int P_RC = 5, P_MRD = 2, P_RCD = 3, P_RASMIN = 5, P_RASMAX = 12, P_RRD = 2;
   localparam logic [3:0] MRS = 0, REF = 1, PRE = 2, ACT = 3, WR = 4, RD = 5, NOP = 7;

   logic clk = 1'b0, rst = 1'b1, cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [0:0] ba = '0;
   logic a10 = 1'b0;
   logic illegal_o, timing_o;
   logic [3:0] rule_o;
   int checks = 0, fails = 0;

   always #2 clk = ~clk;

   sdram_cmd_checker #(
      .BANK_W(1), .T_RC(P_RC), .T_MRD(P_MRD), .T_RCD(P_RCD),
      .T_RAS_MIN(P_RASMIN), .T_RAS_MAX(P_RASMAX), .T_RRD(P_RRD)
   ) u_dut (
      .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
      .we_n(we_n), .ba(ba), .a10(a10),
      .illegal_o(illegal_o), .timing_o(timing_o), .rule_o(rule_o)
   );

   task automatic check(input logic ei, input logic et, input logic [3:0] er, input string tag);
      checks++;
      if (illegal_o !== ei || timing_o !== et || rule_o !== er) begin
         fails++;
         $display("FAIL %s: got ill=%0b tim=%0b rule=%0d, expected ill=%0b tim=%0b rule=%0d",
                  tag, illegal_o, timing_o, rule_o, ei, et, er);
      end
   endtask

   // drive at a falling edge, let one rising edge pass, compare at the next falling edge
   task automatic step(input logic [3:0] c, input logic b, input logic a, input logic k,
                       input logic ei, input logic et, input logic [3:0] er, input string tag);
      cke = k; ba = b; a10 = a;
      if (c == 4'd8) begin
         cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b111;
      end else begin
         cs_n = 1'b0; {ras_n, cas_n, we_n} = c[2:0];
      end
      @(negedge clk);
      check(ei, et, er, tag);
   endtask

   task automatic nops(input int n, input logic k, input string tag);
      for (int i = 0; i < n; i++) step(NOP, 1'b0, 1'b0, k, 1'b0, 1'b0, 4'd0, tag);
   endtask

   task automatic do_reset();
      rst = 1'b1; cs_n = 1'b1; cke = 1'b1;
      @(negedge clk); @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin
      @(negedge clk);
      do_reset();
      check(1'b0, 1'b0, 4'd0, "R1 reset state");
      step(4'd8, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, "R1 deselect");

      // R5 sweep of read spacing after activate
      for (int d = 1; d <= 5; d++) begin
         do_reset();
         step(ACT, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, "R5 activate");
         nops(d - 1, 1'b1, "R5 gap");
         step(RD, 1'b0, 1'b0, 1'b1, 1'b0, d < P_RCD, (d < P_RCD) ? 4'd5 : 4'd0, "R5 read");
      end

      // R6 sweep of precharge spacing
      for (int d = 1; d <= 7; d++) begin
         do_reset();
         step(ACT, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, "R6 activate");
         nops(d - 1, 1'b1, "R6 gap");
         step(PRE, 1'b1, 1'b0, 1'b1, 1'b0, d < P_RASMIN, (d < P_RASMIN) ? 4'd6 : 4'd0, "R6 precharge");
      end

      // R7 sweep of activate-to-activate on different banks
      for (int d = 1; d <= 3; d++) begin
         do_reset();
         step(ACT, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, "R7 first activate");
         nops(d - 1, 1'b1, "R7 gap");
         step(ACT, 1'b1, 1'b0, 1'b1, 1'b0, d < P_RRD, (d < P_RRD) ? 4'd7 : 4'd0, "R7 second activate");
      end

      // R2 sweep after auto refresh
      for (int d = 1; d <= 6; d++) begin
         do_reset();
         step(REF, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, "R2 refresh");
         nops(d - 1, 1'b1, "R2 gap");
         step(ACT, 1'(d % 2), 1'b0, 1'b1, d < P_RC, 1'b0, (d < P_RC) ? 4'd1 : 4'd0, "R2 activate");
      end

      // R3 sweep after mode set
      for (int d = 1; d <= 3; d++) begin
         do_reset();
         step(MRS, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, "R3 mode set");
         nops(d - 1, 1'b1, "R3 gap");
         step(ACT, 1'b1, 1'b0, 1'b1, d < P_MRD, 1'b0, (d < P_MRD) ? 4'd1 : 4'd0, "R3 activate");
      end

      // R4 whole-device commands with a bank open
      do_reset();
      step(ACT, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, "R4 activate");
      nops(1, 1'b1, "R4 gap");
      step(MRS, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 4'd2, "R4 mode set while open");
      step(REF, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 4'd2, "R4 refresh while open");
      step(PRE, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd6, "R4 early precharge");
      step(MRS, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, "R4 mode set all idle");

      // R8 per-bank judgement
      do_reset();
      step(ACT, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, "R8 activate b0");
      nops(2, 1'b1, "R8 gap");
      step(RD, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 4'd4, "R8 read idle b1");
      step(RD, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, "R8 read open b0");
      step(ACT, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd3, "R8 reactivate b0");
      step(ACT, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, "R8 activate b1");

      // R9 auto close
      do_reset();
      step(ACT, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, "R9 activate");
      nops(2, 1'b1, "R9 gap");
      step(RD, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, "R9 read a10 low");
      step(RD, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0, "R9 read a10 high");
      step(RD, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd4, "R9 read after close");
      step(ACT, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, "R9 activate after close");
      step(WR, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd5, "R9 early write");

      // R10 bank left open
      do_reset();
      step(ACT, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, "R10 activate");
      for (int k = 1; k <= P_RASMAX + 3; k++)
         step(NOP, 1'b0, 1'b0, 1'b1, 1'b0, k == P_RASMAX, (k == P_RASMAX) ? 4'd8 : 4'd0, "R10 open too long");
      do_reset();
      step(ACT, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, "R10 activate");
      nops(P_RASMAX - 1, 1'b1, "R10 gap");
      step(PRE, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, "R10 precharge at limit");
      nops(3, 1'b1, "R10 after close");

      // R11 self refresh exit
      for (int d = P_RC - 1; d <= P_RC; d++) begin
         do_reset();
         step(REF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, "R11 enter self refresh");
         nops(6, 1'b0, "R11 held");
         step(ACT, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd1, "R11 activate while held");
         nops(1, 1'b1, "R11 cke rises");
         nops(d - 1, 1'b1, "R11 gap");
         step(ACT, 1'b1, 1'b0, 1'b1, d < P_RC, 1'b0, (d < P_RC) ? 4'd1 : 4'd0, "R11 activate after exit");
      end

      // R12 power-down no-op
      do_reset();
      nops(4, 1'b0, "R12 power-down idle");
      step(ACT, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, "R12 activate");
      step(NOP, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, "R12 power-down open");
      step(RD, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd5, "R12 read still early");
      step(RD, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, "R12 read in time");

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: got no end, expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule